// File: doc/BRIEF.md
# Word-Rate Aligned Clock Enable Generator

This block lives in a fast synchronous clock domain and produces a single-cycle enable strobe once every N fast cycles. N is 6 in the normal ratio and 12 in the long ratio. The strobe is aligned to a slow word-rate signal that a serializer drives. That signal arrives as a plain data input with no fixed phase relation to the fast clock.

The input first passes through a two-flop synchronizer. After reset the block waits for a start-up time-out. It then takes the first synchronized rising edge of the word-rate signal and records where that edge falls within a free-running modulo-N phase count. From that point the strobe repeats at the recorded phase and never follows the input again. The strobe sits around the word-rate rising edge, which is the safe moment for the parallel word to change. Downstream registers and the serializer load act only on strobe cycles. A locked flag reports that the strobe is running.

Top module: `word_rate_enable`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `en_o` and `locked_o` are both 0.
- R2: The ratio N is taken from `long_sel_i` while reset is high (0 selects N=6, 1 selects N=12). A change of `long_sel_i` outside reset has no effect until the next reset.
- R3: `word_clk_i` is sampled on each rising clock edge. Edges are numbered 1, 2, ... from the release of reset, and the sample taken before reset release counts as 0. A rise is a sample of 1 at edge k that follows a sample of 0 at edge k-1.
- R4: A rise sampled at an edge k below TIMEOUT-1 (63 by default) is never used. No strobe appears during the first TIMEOUT cycles after reset.
- R5: Only the first rise with k ≥ TIMEOUT-1 is measured. Later changes on `word_clk_i`, including a stopped or phase-shifted input, do not move the strobe.
- R6: Once the rise at edge k has been measured, `en_o` is high in exactly the cycles that end on edges numbered k+N, k+2N, and so on.
- R7: `en_o` is one cycle wide, and two successive strobes are exactly N cycles apart.
- R8: `locked_o` rises in the cycle after the first strobe and stays high until reset.
- R9: Reset applied while the strobe is running clears `locked_o` and the strobe. The whole wait-and-measure sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synchronous clock |
| rst | input | 1 | Synchronous reset, active high |
| word_clk_i | input | 1 | Word-rate signal from the serializer, asynchronous |
| long_sel_i | input | 1 | Ratio select: 0 gives N=6, 1 gives N=12; sampled during reset |
| en_o | output | 1 | One-cycle enable strobe, repeating every N cycles |
| locked_o | output | 1 | High from the cycle after the first strobe until reset |

## Verification
Two events can land in the same cycle: the expiry of the start-up time-out and the first synchronized rise of the word-rate input. When they coincide, the order in which they are resolved decides whether this rise is measured or a later one is. The bench sweeps the phase offset of the word-rate stimulus through every residue of N. As a result, some runs place the first rise exactly at edge 63 and others one edge earlier. A behavioural model compares the strobe and locked flag on every cycle, so measuring the wrong rise shows up as a strobe one whole word period away from the expected one.

// File: rtl/word_rate_enable.sv
module word_rate_enable #(
  parameter int TIMEOUT   = 64,
  parameter int DIV_SHORT = 6,
  parameter int DIV_LONG  = 12,
  parameter int SYNC_LAT  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic word_clk_i,
  input  logic long_sel_i,
  output logic en_o,
  output logic locked_o
);
  localparam int PW = $clog2(DIV_LONG + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [SYNC_LAT:0] sync_q;
  logic              long_q;
  logic [PW-1:0]     phase_q;
  logic [PW-1:0]     target_q;
  logic [TW-1:0]     wait_q;
  logic              armed_q;
  logic              locked_q;

  logic [PW-1:0] ratio;
  logic [PW-1:0] back_phase;
  logic          expired;
  logic          rise;

  assign ratio      = long_q ? PW'(DIV_LONG) : PW'(DIV_SHORT);
  assign expired    = (wait_q == TW'(TIMEOUT));
  assign rise       = sync_q[SYNC_LAT-1] & ~sync_q[SYNC_LAT];
  assign back_phase = (phase_q >= PW'(SYNC_LAT)) ? phase_q - PW'(SYNC_LAT)
                                                 : phase_q + ratio - PW'(SYNC_LAT);
  assign en_o       = armed_q && (phase_q == target_q);
  assign locked_o   = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      long_q   <= long_sel_i;
      phase_q  <= '0;
      target_q <= '0;
      wait_q   <= '0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_LAT-1:0], word_clk_i};
      phase_q <= (phase_q == ratio - PW'(1)) ? '0 : phase_q + PW'(1);
      if (!expired)
        wait_q <= wait_q + TW'(1);
      if (expired && rise && !armed_q) begin
        armed_q  <= 1'b1;
        target_q <= back_phase;
      end
      if (en_o)
        locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/word_rate_enable_chk.sv
module word_rate_enable_chk #(
  parameter int TIMEOUT   = 64,
  parameter int DIV_SHORT = 6,
  parameter int DIV_LONG  = 12
) (
  input logic clk,
  input logic rst,
  input logic word_clk_i,
  input logic long_sel_i,
  input logic en_o,
  input logic locked_o
);
  logic       mode_q;
  logic       seen_q;
  logic [7:0] gap_q;
  logic [7:0] age_q;
  logic [7:0] n_sel;

  assign n_sel = mode_q ? 8'(DIV_LONG) : 8'(DIV_SHORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= long_sel_i;
      seen_q <= 1'b0;
      gap_q  <= '0;
      age_q  <= '0;
    end else begin
      if (age_q != 8'hFF) age_q <= age_q + 8'd1;
      if (en_o) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != 8'hFF) begin
        gap_q <= gap_q + 8'd1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!en_o && !locked_o));
  a_r4_no_early_strobe: assert property (@(posedge clk) disable iff (rst)
    (age_q < 8'(TIMEOUT)) |-> !en_o);
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst) en_o |=> !en_o);
  a_r7_period: assert property (@(posedge clk) disable iff (rst)
    (en_o && seen_q) |-> (gap_q == n_sel - 8'd1));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst) locked_o |=> locked_o);
  a_r8_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(en_o));
endmodule

bind word_rate_enable word_rate_enable_chk #(
  .TIMEOUT(TIMEOUT), .DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG)
) u_chk (
  .clk(clk), .rst(rst), .word_clk_i(word_clk_i), .long_sel_i(long_sel_i),
  .en_o(en_o), .locked_o(locked_o)
);

// File: tb/word_rate_enable_test.sv
module word_rate_enable_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_clk_i = 1'b0;
  logic long_sel_i = 1'b0;
  logic en_o, locked_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  word_rate_enable uut (
    .clk(clk), .rst(rst), .word_clk_i(word_clk_i), .long_sel_i(long_sel_i),
    .en_o(en_o), .locked_o(locked_o)
  );

  int  m_edge, m_rise, m_n;
  bit  m_prev, m_en, m_locked;

  always @(posedge clk) begin
    if (rst) begin
      m_edge = 0; m_rise = -1; m_prev = 0; m_en = 0; m_locked = 0;
      m_n = long_sel_i ? 12 : 6;
    end else begin
      m_locked = m_locked | m_en;
      m_edge++;
      if (m_rise < 0 && word_clk_i && !m_prev && m_edge >= 63) m_rise = m_edge;
      m_prev = word_clk_i;
      m_en = (m_rise >= 0) && (m_edge >= m_rise + 2) && (((m_edge + 1 - m_rise) % m_n) == 0);
    end
  end

  int last_en = -1;
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (en_o !== m_en) begin
        errors++;
        $display("FAIL %s en_o actual %b expected %b at edge %0d",
                 rst ? "R1" : (m_rise < 0 ? "R4" : "R6"), en_o, m_en, m_edge);
      end
      checks++;
      if (locked_o !== m_locked) begin
        errors++;
        $display("FAIL %s locked_o actual %b expected %b at edge %0d",
                 rst ? "R1" : "R8", locked_o, m_locked, m_edge);
      end
      if (rst) last_en = -1;
      else if (en_o === 1'b1) begin
        if (last_en >= 0) begin
          checks++;
          if (m_edge - last_en != m_n) begin
            errors++;
            $display("FAIL R7 strobe spacing actual %0d expected %0d", m_edge - last_en, m_n);
          end
        end
        last_en = m_edge;
      end
    end
  end

  int  s_n, s_off, s_per;
  bit  s_hold, s_val;
  always @(negedge clk) begin
    s_n++;
    word_clk_i <= s_hold ? s_val : (((s_n + s_off) % s_per) < (s_per / 2));
  end

  task automatic run_case(input bit lm, input int per, input int off, input int cycles);
    @(negedge clk);
    rst = 1'b1; long_sel_i = lm;
    s_hold = 0; s_per = per; s_off = off;
    repeat (3) @(negedge clk);
    rst = 1'b0; s_n = 0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    s_per = 6; s_n = 0; s_off = 0; s_hold = 0; s_val = 0;
    // R1 R3 R4 R6 R7 R8: short ratio, every phase residue around the time-out edge
    for (int o = 0; o < 6; o++) run_case(1'b0, 6, o, 200);
    // R2 long ratio, several residues
    for (int o = 0; o < 12; o += 5) run_case(1'b1, 12, o, 260);
    // R5: after lock, input stops high, then shifts phase; strobe must not move
    run_case(1'b0, 6, 3, 120);
    s_hold = 1; s_val = 1; repeat (40) @(negedge clk);
    s_hold = 0; s_off = 1; repeat (60) @(negedge clk);
    s_per = 12; repeat (60) @(negedge clk);
    // R2: ratio select toggled while running has no effect
    run_case(1'b0, 6, 4, 120);
    long_sel_i = 1'b1; repeat (80) @(negedge clk);
    // R9: reset mid-run, then a new measurement with another phase
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0; s_n = 0; s_off = 2; long_sel_i = 1'b0;
    repeat (150) @(negedge clk);
    // R3: input already high when reset is released
    @(negedge clk); rst = 1'b1; s_hold = 1; s_val = 1; long_sel_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; s_n = 0; repeat (70) @(negedge clk);
    s_hold = 0; s_off = 0; repeat (100) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    done = 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule